// File: doc/BRIEF.md
# Looped Audio DMA Channel Position Counter

This block keeps the position and sample-count bookkeeping for one channel of an audio DMA engine that cycles through a circular buffer in memory. Software programs three values: a buffer base address, a frame register that holds the buffer size and the current position, and a sample register that holds the programmed block length and the count that remains. When the audio sink or source offers some number of bytes, the block works out which memory address the bus master should use and how many bytes it should move. The bus master then reports how many bytes it actually moved, and the block advances its counters.

The position is counted in 32-bit words. Bytes left over inside a word are carried from one service to the next. The sample count is kept in sample frames, and the size of a frame in bytes depends on the mono/stereo and 8/16-bit format. When the remaining count runs out, the block reloads it from the programmed length and raises a one-cycle block-done pulse. Moving the data itself, the bus protocol and the memory are all handled outside this block.

Top module: `lpdma_chan`

## Requirements
- R1: After reset, base_o, frame_cnt_o, sample_cnt_o and leftover_o are all zero, and xfer_vld_o and block_done_o are low.
- R2: A write with wr_sel_i=1 loads all of frame_cnt_o and clears leftover_o. A write with wr_sel_i=0 loads base_o. A write with wr_sel_i=2 changes only sample_cnt_o[15:0]. A write with wr_sel_i=3 changes nothing.
- R3: The frame shift is fmt_i[0] (stereo) plus fmt_i[1] (16-bit), so a sample frame is 1, 2, 2 or 4 bytes. The offered byte count is rounded down to a whole number of sample frames before it is used.
- R4: xfer_len_o is the smallest of three values: the rounded offer; the block bytes, which are (sample_cnt_o[31:16]+1) shifted left by the shift; and the buffer bytes, which are (size − position + 1)×4 + leftover. Size is frame_cnt_o[15:0] and position is frame_cnt_o[31:16]. The buffer bytes are 0 when position > size.
- R5: xfer_addr_o is base + position×4 + leftover.
- R6: When req_i is high at a clock edge with en_i=1, pause_i=0 and a nonzero length, xfer_vld_o is high for the following cycle and xfer_addr_o and xfer_len_o carry that service.
- R7: A request made while en_i=0, while pause_i=1, or with a length of zero produces no xfer_vld_o and leaves xfer_addr_o and xfer_len_o unchanged.
- R8: When a report with moved_i equal to the block bytes arrives, sample_cnt_o[31:16] reloads from sample_cnt_o[15:0] and block_done_o is high for one cycle.
- R9: When a report with moved_i smaller than the block bytes arrives, sample_cnt_o[31:16] becomes (block bytes − moved − 1) >> shift and block_done_o stays low.
- R10: A report sets the leftover to (moved + leftover) & 3 and computes a new position = position + ((moved + leftover) >> 2). With loop_sel_i=0 (loop mode), that new position is stored if it does not exceed size; otherwise the position becomes 0.
- R11: With loop_sel_i=1, a report leaves frame_cnt_o unchanged but still updates leftover_o and the sample count.
- R12: Counter updates caused by a report become visible in the cycle after done_vld_i. Without a report or a write, the counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| pause_i | input | 1 | Channel pause |
| loop_sel_i | input | 1 | 0 = loop mode, 1 = position frozen |
| fmt_i | input | 2 | bit0 stereo, bit1 16-bit |
| wr_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | 0 base, 1 frame, 2 sample, 3 none |
| wr_data_i | input | 32 | Write data |
| req_i | input | 1 | Service request |
| offer_i | input | 16 | Bytes the sink or source can take |
| xfer_vld_o | output | 1 | Service granted, one cycle |
| xfer_addr_o | output | 32 | Transfer start address |
| xfer_len_o | output | 19 | Transfer length in bytes |
| done_vld_i | input | 1 | Completion report strobe |
| moved_i | input | 19 | Bytes actually moved |
| block_done_o | output | 1 | Sample block finished, one cycle |
| base_o | output | 32 | Buffer base address |
| frame_cnt_o | output | 32 | {position, size} in words |
| sample_cnt_o | output | 32 | {remaining, programmed} in frames |
| leftover_o | output | 2 | Carried sub-word bytes |

## Verification
The hardest situations to reach are a nonzero leftover that coincides with a wrap of the position, and a position that lies beyond the size. The bench reaches the first by giving short reports, so that moved is one less than the length or half of it, over every format and a range of offers on a six-word buffer. Those reports drive leftover and position through every residue. For the second, it writes a frame value with the position above the size, which must produce a zero-length service that is skipped. The sweep runs twice, once with a block shorter than the buffer and once with a longer block, so that each of the three limits on the length takes its turn as the smallest.

// File: rtl/lpdma_pkg.sv
package lpdma_pkg;
  typedef enum logic [1:0] {SEL_BASE, SEL_FRAME, SEL_SAMPLE, SEL_NONE} sel_e;

  function automatic logic [1:0] frame_shift(input logic [1:0] fmt);
    return {1'b0, fmt[0]} + {1'b0, fmt[1]};
  endfunction
endpackage

// File: rtl/lpdma_regs.sv
module lpdma_regs #(
  parameter int CW = 16,
  localparam int DW = 2 * CW,
  localparam int AW = DW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  lpdma_pkg::sel_e    wr_sel_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic               upd_i,
  input  logic               upd_pos_i,
  input  logic [CW-1:0]      pos_nxt_i,
  input  logic [1:0]         lo_nxt_i,
  input  logic [CW-1:0]      csc_nxt_i,
  output logic [AW-1:0]      base_o,
  output logic [CW-1:0]      size_o,
  output logic [CW-1:0]      pos_o,
  output logic [1:0]         lo_o,
  output logic [CW-1:0]      sc_o,
  output logic [CW-1:0]      csc_o
);
  import lpdma_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      size_o <= '0;
      pos_o  <= '0;
      lo_o   <= '0;
      sc_o   <= '0;
      csc_o  <= '0;
    end else begin
      if (wr_i && wr_sel_i == SEL_BASE) base_o <= wr_data_i[AW-1:0];
      // frame write overrides a same-cycle completion
      if (wr_i && wr_sel_i == SEL_FRAME) begin
        size_o <= wr_data_i[CW-1:0];
        pos_o  <= wr_data_i[DW-1:CW];
        lo_o   <= '0;
      end else if (upd_i) begin
        if (upd_pos_i) pos_o <= pos_nxt_i;
        lo_o <= lo_nxt_i;
      end
      if (wr_i && wr_sel_i == SEL_SAMPLE) sc_o <= wr_data_i[CW-1:0];
      if (upd_i) csc_o <= csc_nxt_i;
    end
  end
endmodule

// File: rtl/lpdma_size.sv
module lpdma_size #(
  parameter int CW = 16,
  parameter int OW = 16,
  localparam int AW = 2 * CW,
  localparam int LW = CW + 3
) (
  input  logic [1:0]    fmt_i,
  input  logic [OW-1:0] offer_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] size_i,
  input  logic [CW-1:0] pos_i,
  input  logic [1:0]    lo_i,
  input  logic [CW-1:0] csc_i,
  output logic [1:0]    shift_o,
  output logic [LW-1:0] blk_o,
  output logic [LW-1:0] len_o,
  output logic [AW-1:0] addr_o,
  output logic          go_o
);
  logic [OW-1:0] mask, offer_r;
  logic [LW-1:0] offer_x, span, buf_b, m1;
  logic [CW:0]   cnt1;

  always_comb begin
    shift_o = lpdma_pkg::frame_shift(fmt_i);
    mask    = ~((OW'(1) << shift_o) - OW'(1));
    offer_r = offer_i & mask;
    offer_x = LW'(offer_r);
    cnt1    = {1'b0, csc_i} + (CW+1)'(1);
    blk_o   = LW'(cnt1) << shift_o;
    span    = LW'(size_i) - LW'(pos_i) + LW'(1);
    buf_b   = (pos_i > size_i) ? '0 : (span << 2) + LW'(lo_i);
    m1      = (offer_x < blk_o) ? offer_x : blk_o;
    len_o   = (m1 < buf_b) ? m1 : buf_b;
    go_o    = |len_o;
    addr_o  = base_i + AW'({pos_i, 2'b00}) + AW'(lo_i);
  end
endmodule

// File: rtl/lpdma_adv.sv
module lpdma_adv #(
  parameter int CW = 16,
  localparam int LW = CW + 3
) (
  input  logic [LW-1:0] moved_i,
  input  logic [LW-1:0] blk_i,
  input  logic [1:0]    shift_i,
  input  logic [CW-1:0] pos_i,
  input  logic [CW-1:0] size_i,
  input  logic [1:0]    lo_i,
  input  logic [CW-1:0] sc_i,
  output logic [CW-1:0] pos_o,
  output logic [1:0]    lo_o,
  output logic [CW-1:0] csc_o,
  output logic          full_o
);
  logic [LW-1:0] rem, sum, np;

  always_comb begin
    full_o = (moved_i == blk_i);
    rem    = blk_i - moved_i - LW'(1);
    csc_o  = full_o ? sc_i : CW'(rem >> shift_i);
    sum    = moved_i + LW'(lo_i);
    np     = LW'(pos_i) + (sum >> 2);
    pos_o  = (np <= LW'(size_i)) ? np[CW-1:0] : '0;
    lo_o   = sum[1:0];
  end
endmodule

// File: rtl/lpdma_chan.sv
module lpdma_chan #(
  parameter int CW = 16,
  parameter int OW = 16,
  localparam int DW = 2 * CW,
  localparam int AW = DW,
  localparam int LW = CW + 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          pause_i,
  input  logic          loop_sel_i,
  input  logic [1:0]    fmt_i,
  input  logic          wr_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          req_i,
  input  logic [OW-1:0] offer_i,
  output logic          xfer_vld_o,
  output logic [AW-1:0] xfer_addr_o,
  output logic [LW-1:0] xfer_len_o,
  input  logic          done_vld_i,
  input  logic [LW-1:0] moved_i,
  output logic          block_done_o,
  output logic [AW-1:0] base_o,
  output logic [DW-1:0] frame_cnt_o,
  output logic [DW-1:0] sample_cnt_o,
  output logic [1:0]    leftover_o
);
  logic [CW-1:0] size, pos, sc, csc, pos_nxt, csc_nxt;
  logic [1:0]    lo, lo_nxt, shift;
  logic [LW-1:0] blk, len;
  logic [AW-1:0] addr;
  logic          go, full, grant;

  lpdma_regs #(.CW(CW)) u_regs (
    .clk_i, .rst_ni, .wr_i,
    .wr_sel_i  (lpdma_pkg::sel_e'(wr_sel_i)),
    .wr_data_i,
    .upd_i     (done_vld_i),
    .upd_pos_i (!loop_sel_i),
    .pos_nxt_i (pos_nxt),
    .lo_nxt_i  (lo_nxt),
    .csc_nxt_i (csc_nxt),
    .base_o,
    .size_o    (size),
    .pos_o     (pos),
    .lo_o      (lo),
    .sc_o      (sc),
    .csc_o     (csc)
  );

  lpdma_size #(.CW(CW), .OW(OW)) u_size (
    .fmt_i, .offer_i,
    .base_i  (base_o),
    .size_i  (size),
    .pos_i   (pos),
    .lo_i    (lo),
    .csc_i   (csc),
    .shift_o (shift),
    .blk_o   (blk),
    .len_o   (len),
    .addr_o  (addr),
    .go_o    (go)
  );

  lpdma_adv #(.CW(CW)) u_adv (
    .moved_i, .shift_i(shift),
    .blk_i  (blk),
    .pos_i  (pos),
    .size_i (size),
    .lo_i   (lo),
    .sc_i   (sc),
    .pos_o  (pos_nxt),
    .lo_o   (lo_nxt),
    .csc_o  (csc_nxt),
    .full_o (full)
  );

  assign grant = req_i && en_i && !pause_i && go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_vld_o   <= 1'b0;
      xfer_addr_o  <= '0;
      xfer_len_o   <= '0;
      block_done_o <= 1'b0;
    end else begin
      xfer_vld_o   <= grant;
      block_done_o <= done_vld_i && full;
      if (grant) begin
        xfer_addr_o <= addr;
        xfer_len_o  <= len;
      end
    end
  end

  assign frame_cnt_o  = {pos, size};
  assign sample_cnt_o = {csc, sc};
  assign leftover_o   = lo;
endmodule

// File: rtl/lpdma_chan_chk.sv
module lpdma_chan_chk #(
  parameter int CW = 16,
  parameter int OW = 16,
  localparam int DW = 2 * CW,
  localparam int AW = DW,
  localparam int LW = CW + 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          pause_i,
  input logic          loop_sel_i,
  input logic [1:0]    fmt_i,
  input logic          wr_i,
  input logic [1:0]    wr_sel_i,
  input logic [DW-1:0] wr_data_i,
  input logic          req_i,
  input logic [OW-1:0] offer_i,
  input logic          xfer_vld_o,
  input logic [AW-1:0] xfer_addr_o,
  input logic [LW-1:0] xfer_len_o,
  input logic          done_vld_i,
  input logic [LW-1:0] moved_i,
  input logic          block_done_o,
  input logic [AW-1:0] base_o,
  input logic [DW-1:0] frame_cnt_o,
  input logic [DW-1:0] sample_cnt_o,
  input logic [1:0]    leftover_o
);
  AST_OFF_NO_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (!en_i || pause_i)) |=> !xfer_vld_o); // R7
  AST_XFER_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_vld_o |-> ($past(req_i) && $past(en_i) && !$past(pause_i))); // R6
  AST_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_vld_o |-> (xfer_len_o != '0 && xfer_len_o <= LW'($past(offer_i)))); // R4
  AST_DONE_FROM_REPORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_done_o |-> $past(done_vld_i)); // R8
  AST_DONE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (block_done_o && !$past(wr_i)) |-> (sample_cnt_o[DW-1:CW] == sample_cnt_o[CW-1:0])); // R8
  AST_LOOP_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_vld_i && !loop_sel_i && !wr_i && frame_cnt_o[DW-1:CW] <= frame_cnt_o[CW-1:0])
      |=> (frame_cnt_o[DW-1:CW] <= frame_cnt_o[CW-1:0])); // R10
  AST_FRAME_WR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_sel_i == 2'd1) |=> (leftover_o == 2'd0)); // R2
  AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_vld_i && !wr_i) |=> ($stable(frame_cnt_o) && $stable(sample_cnt_o) && $stable(leftover_o))); // R12
  AST_NONLOOP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_vld_i && loop_sel_i && !wr_i) |=> $stable(frame_cnt_o)); // R11
endmodule

bind lpdma_chan lpdma_chan_chk #(.CW(CW), .OW(OW)) u_chk (.*);

// File: tb/tb_lpdma_chan.sv
module tb_lpdma_chan;
  localparam int CW = 16, OW = 16, DW = 32, LW = CW + 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en_i = 1'b0, pause_i = 1'b0, loop_sel_i = 1'b0;
  logic [1:0] fmt_i = '0, wr_sel_i = '0;
  logic wr_i = 1'b0, req_i = 1'b0, done_vld_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic [OW-1:0] offer_i = '0;
  logic [LW-1:0] moved_i = '0;
  logic xfer_vld_o, block_done_o;
  logic [DW-1:0] xfer_addr_o, base_o, frame_cnt_o, sample_cnt_o;
  logic [LW-1:0] xfer_len_o;
  logic [1:0] leftover_o;

  always #5 clk = ~clk;

  lpdma_chan #(.CW(CW), .OW(OW)) dut (.clk_i(clk), .*);

  int n_chk = 0, n_err = 0;
  int m_base, m_size, m_pos, m_lo, m_sc, m_csc;

  task automatic check(string r, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr(int sel, logic [31:0] d);
    @(negedge clk);
    wr_i = 1'b1; wr_sel_i = 2'(sel); wr_data_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic check_regs(string r);
    check({r, " base"}, base_o, m_base);
    check({r, " frame"}, frame_cnt_o, (longint'(m_pos) << 16) | m_size);
    check({r, " sample"}, sample_cnt_o, (longint'(m_csc) << 16) | m_sc);
    check({r, " leftover"}, leftover_o, m_lo);
  endtask

  // mode: 0 full length, 1 one byte short, 2 half
  task automatic service(int offer, int mode);
    int sh, rnd, blk, bufb, len, moved, sum, np;
    longint prev_addr, prev_len;
    sh = fmt_i[0] + fmt_i[1];
    rnd = (offer >> sh) << sh;
    blk = (m_csc + 1) << sh;
    bufb = (m_pos > m_size) ? 0 : (m_size - m_pos + 1) * 4 + m_lo;
    len = rnd < blk ? rnd : blk;
    len = len < bufb ? len : bufb;
    prev_addr = xfer_addr_o; prev_len = xfer_len_o;
    @(negedge clk);
    req_i = 1'b1; offer_i = 16'(offer);
    @(negedge clk);
    req_i = 1'b0;
    if (len == 0 || !en_i || pause_i) begin
      check("R7 no grant", xfer_vld_o, 0);
      check("R7 addr held", xfer_addr_o, prev_addr);
      check("R7 len held", xfer_len_o, prev_len);
    end else begin
      check("R6 grant", xfer_vld_o, 1);
      check("R5 addr", xfer_addr_o, (longint'(m_base) + m_pos * 4 + m_lo) & 64'hFFFF_FFFF);
      check("R3 R4 len", xfer_len_o, len);
      moved = (mode == 0) ? len : (mode == 1) ? len - 1 : len / 2;
      done_vld_i = 1'b1; moved_i = LW'(moved);
      @(negedge clk);
      done_vld_i = 1'b0;
      check("R6 single cycle", xfer_vld_o, 0);
      if (moved == blk) begin
        m_csc = m_sc;
        check("R8 block done", block_done_o, 1);
      end else begin
        m_csc = (blk - moved - 1) >> sh;
        check("R9 no done", block_done_o, 0);
      end
      sum = moved + m_lo;
      m_lo = sum & 3;
      np = m_pos + (sum >> 2);
      if (!loop_sel_i) m_pos = (np <= m_size) ? np : 0;
      check_regs(loop_sel_i ? "R11" : "R10 R12");
      @(negedge clk);
      check("R8 pulse", block_done_o, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int offers[8] = '{0, 1, 2, 3, 5, 7, 16, 29};
    int scs[2] = '{6, 40};
    m_base = 0; m_size = 0; m_pos = 0; m_lo = 0; m_sc = 0; m_csc = 0;
    repeat (3) @(negedge clk);
    check("R1 vld", xfer_vld_o, 0);
    check("R1 done", block_done_o, 0);
    check_regs("R1");
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 register writes
    wr(0, 32'h1000_0F00); m_base = 32'h1000_0F00;
    wr(1, 32'h0000_0005); m_size = 5;
    wr(2, 32'hABCD_0006); m_sc = 6;
    check_regs("R2 writes");
    wr(3, 32'hFFFF_FFFF);
    check_regs("R2 sel3 ignored");
    @(negedge clk);
    check_regs("R12 idle hold");

    en_i = 1'b1;
    foreach (scs[k]) begin
      wr(2, 32'(scs[k])); m_sc = scs[k];
      for (int f = 0; f < 4; f++) begin
        fmt_i = 2'(f);
        foreach (offers[i])
          for (int md = 0; md < 3; md++) service(offers[i], md);
      end
    end

    // R2 frame write clears leftover
    fmt_i = 2'd0;
    if (m_lo == 0) service(3, 0);
    wr(1, 32'h0002_0005); m_pos = 2; m_lo = 0;
    check_regs("R2 frame clears leftover");

    // R11 position frozen outside loop mode
    loop_sel_i = 1'b1;
    for (int i = 0; i < 6; i++) service(5 + i, i % 3);
    loop_sel_i = 1'b0;

    // R7 disabled, paused, out-of-range position
    en_i = 1'b0; service(16, 0);
    en_i = 1'b1; pause_i = 1'b1; service(16, 0);
    pause_i = 1'b0;
    wr(1, 32'h0009_0005); m_pos = 9; m_lo = 0;
    service(16, 0);
    check_regs("R7 state untouched");
    wr(1, 32'h0000_0005); m_pos = 0;
    service(16, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule